// File: doc/BRIEF.md
# Configuration Request Engine with Programmed I/O

The engine sits between a host processor's 32-bit register bus and the request port of a PCIe link layer. Software programs a transaction code, a configuration address, write data and a byte-enable mask. It then sets the launch bit. The engine issues exactly one request on the link side and waits for its completion. The outcome is captured in a status word, in a read-data register and in a sticky done flag.

Only one request is outstanding at a time. While a request is in flight, the programming registers are frozen and further launch attempts are ignored. A cycle counter abandons the request if no completion comes back within `TIMEOUT_CYCLES` clocks. With the default of 100000 clocks, this is about 1 ms at 100 MHz. A timed-out request reports a timeout flag and returns all-ones read data. Software must clear the done flag, by writing 1 to it, before it can launch again.

Host register word offsets (`bus_addr_i`): 0 control, 1 status, 2 address, 3 write data, 4 byte enables, 5 read data, 6 launch, 7 done flag.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, the launch, done flag, status, read data, control and address registers all read 0, and `req_valid_o` is 0.
- R2: The control register keeps only the transaction code in bits [3:0] and the window-bypass bit in bit 24. The address register keeps only bits [27:2] (bus [27:20], device [19:15], function [14:12], dword offset [11:2]). The byte-enable register keeps bits [3:0]. All other bits read 0. The kept fields drive `req_type_o`, `req_win_bypass_o` and `req_addr_o`.
- R3: Writing 1 to bit 0 of the launch register, while idle and with the done flag clear, raises `req_valid_o` after the next clock edge. The launch register then reads 1 until the request finishes.
- R4: `req_valid_o` and the request fields stay constant until the clock edge where `req_ready_i` is 1. `req_valid_o` is 0 after that edge.
- R5: When a completion is accepted, the launch register reads 0 and the done flag reads 1 from the same edge. Writing 1 to bit 0 of the done flag clears it.
- R6: A launch write is ignored while a request is in flight or while the done flag is set. No request is issued.
- R7: The status register holds the completion code in bits [9:7]: 0 OK, 1 unsupported request, 2 configuration retry, 4 completer abort. Bit 0 is set when the transaction code is one of 0x8, 0x9, 0xA, 0xB (non-posted configuration access). Bit 10 marks a timeout.
- R8: The read-data register is loaded from `cpl_data_i` only when the completion code is 0. Any other code leaves it unchanged.
- R9: For read codes 0x8 and 0x9, `req_strb_o` is 0xF regardless of the byte-enable register. For any other code, `req_strb_o` is the programmed byte enables and `req_wdata_o` is the programmed write data.
- R10: If no completion arrives within `TIMEOUT_CYCLES` clocks of the launch, the request is abandoned. The launch register returns to 0, the done flag sets, status bit 10 sets with code 0, and the read data becomes 0xFFFFFFFF.
- R11: Writes to the control, address, write-data and byte-enable registers are ignored while a request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Host register write strobe |
| bus_addr_i | input | 3 | Host register word offset |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Readback of the addressed register |
| req_valid_o | output | 1 | Link request valid |
| req_ready_i | input | 1 | Link accepts the request |
| req_type_o | output | 4 | Transaction code |
| req_addr_o | output | 32 | Configuration address |
| req_wdata_o | output | 32 | Write payload |
| req_strb_o | output | 4 | Byte enables |
| req_win_bypass_o | output | 1 | Bypass outbound address translation |
| cpl_valid_i | input | 1 | Completion valid |
| cpl_status_i | input | 3 | Completion code |
| cpl_data_i | input | 32 | Completion read data |

## Verification
The bench builds the engine with `TIMEOUT_CYCLES` set to 64. This brings the abandon path, and the exact cycle window around it, within a few dozen clocks instead of a hundred thousand. A link responder with adjustable accept and completion delays holds each request in flight long enough to try frozen-register writes and repeated launches. It also returns every completion code, so status packing and the conditional read-data update are all reached.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
  localparam int DW = 32;
  localparam int RAW = 3;
  localparam logic [RAW-1:0] OFS_CTRL  = 3'd0;
  localparam logic [RAW-1:0] OFS_STAT  = 3'd1;
  localparam logic [RAW-1:0] OFS_ADDR  = 3'd2;
  localparam logic [RAW-1:0] OFS_WDATA = 3'd3;
  localparam logic [RAW-1:0] OFS_STRB  = 3'd4;
  localparam logic [RAW-1:0] OFS_RDATA = 3'd5;
  localparam logic [RAW-1:0] OFS_START = 3'd6;
  localparam logic [RAW-1:0] OFS_ISR   = 3'd7;
  localparam int BYPASS_BIT = 24;
  localparam int CPL_LSB    = 7;
  localparam int TMO_BIT    = 10;
  localparam logic [2:0] CPL_OK = 3'd0;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} seq_state_e;

  function automatic logic [DW-1:0] pack_stat(input logic tmo, input logic [2:0] code,
                                              input logic np);
    logic [DW-1:0] s;
    s = '0;
    s[TMO_BIT] = tmo;
    s[CPL_LSB +: 3] = code;
    s[0] = np;
    return s;
  endfunction
endpackage

// File: rtl/cfg_pio_regs.sv
module cfg_pio_regs
  import cfg_pio_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [RAW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           busy_i,
  input  logic           isr_i,
  input  logic [DW-1:0]  stat_i,
  input  logic [DW-1:0]  rdata_i,
  output logic [3:0]     type_o,
  output logic           bypass_o,
  output logic [DW-1:0]  cfg_addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic [3:0]     strb_o,
  output logic [DW-1:0]  bus_rdata_o
);
  logic [3:0]  type_q;
  logic        byp_q;
  logic [25:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [3:0]  strb_q;
  logic        wr_ok;

  assign wr_ok = wr_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q  <= '0;
      byp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      strb_q  <= '0;
    end else if (wr_ok) begin
      case (addr_i)
        OFS_CTRL: begin
          type_q <= wdata_i[3:0];
          byp_q  <= wdata_i[BYPASS_BIT];
        end
        OFS_ADDR:  addr_q  <= wdata_i[27:2];
        OFS_WDATA: wdata_q <= wdata_i;
        OFS_STRB:  strb_q  <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  assign type_o     = type_q;
  assign bypass_o   = byp_q;
  assign cfg_addr_o = {4'b0, addr_q, 2'b0};
  assign wdata_o    = wdata_q;
  assign strb_o     = strb_q;

  always_comb begin
    bus_rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        bus_rdata_o[3:0] = type_q;
        bus_rdata_o[BYPASS_BIT] = byp_q;
      end
      OFS_STAT:  bus_rdata_o = stat_i;
      OFS_ADDR:  bus_rdata_o = cfg_addr_o;
      OFS_WDATA: bus_rdata_o = wdata_q;
      OFS_STRB:  bus_rdata_o[3:0] = strb_q;
      OFS_RDATA: bus_rdata_o = rdata_i;
      OFS_START: bus_rdata_o[0] = busy_i;
      OFS_ISR:   bus_rdata_o[0] = isr_i;
      default: ;
    endcase
  end

  AST_REGS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(addr_q) && $stable(type_q) && $stable(strb_q) && $stable(wdata_q))); // R11
endmodule

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  AST_EXPIRE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !run_i); // R10
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
  import cfg_pio_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [RAW-1:0] addr_i,
  input  logic           wbit0_i,
  input  logic           np_i,
  input  logic           expire_i,
  input  logic           req_ready_i,
  input  logic           cpl_valid_i,
  input  logic [2:0]     cpl_status_i,
  input  logic [DW-1:0]  cpl_data_i,
  output logic           launch_o,
  output logic           busy_o,
  output logic           req_valid_o,
  output logic           isr_o,
  output logic [DW-1:0]  stat_o,
  output logic [DW-1:0]  rdata_o
);
  seq_state_e state_q;
  logic isr_q;
  logic [DW-1:0] stat_q, rdata_q;
  logic cpl_hit, tmo_hit;

  assign launch_o = wr_i && (addr_i == OFS_START) && wbit0_i && (state_q == ST_IDLE) && !isr_q;
  assign cpl_hit  = (state_q == ST_WAIT) && cpl_valid_i;
  // completion beats expiry in the same cycle
  assign tmo_hit  = (state_q != ST_IDLE) && expire_i && !cpl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      isr_q   <= 1'b0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch_o) state_q <= ST_REQ;
        ST_REQ: begin
          if (tmo_hit)          state_q <= ST_IDLE;
          else if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: if (cpl_hit || tmo_hit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

      if (cpl_hit || tmo_hit)                            isr_q <= 1'b1;
      else if (wr_i && (addr_i == OFS_ISR) && wbit0_i)   isr_q <= 1'b0;

      if (cpl_hit)      stat_q <= pack_stat(1'b0, cpl_status_i, np_i);
      else if (tmo_hit) stat_q <= pack_stat(1'b1, 3'd0, np_i);

      if (cpl_hit && (cpl_status_i == CPL_OK)) rdata_q <= cpl_data_i;
      else if (tmo_hit)                        rdata_q <= '1;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign isr_o       = isr_q;
  assign stat_o      = stat_q;
  assign rdata_o     = rdata_q;

  AST_REQ_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !isr_q); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i && !expire_i) |=> req_valid_o); // R4
  AST_FINISH_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> isr_q); // R5
  AST_TMO_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_hit |=> (rdata_q == '1 && stat_q[TMO_BIT])); // R10
  AST_BAD_CPL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_hit && cpl_status_i != CPL_OK) |=> $stable(rdata_q)); // R8
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import cfg_pio_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_wr_i,
  input  logic [2:0]     bus_addr_i,
  input  logic [31:0]    bus_wdata_i,
  output logic [31:0]    bus_rdata_o,
  output logic           req_valid_o,
  input  logic           req_ready_i,
  output logic [3:0]     req_type_o,
  output logic [31:0]    req_addr_o,
  output logic [31:0]    req_wdata_o,
  output logic [3:0]     req_strb_o,
  output logic           req_win_bypass_o,
  input  logic           cpl_valid_i,
  input  logic [2:0]     cpl_status_i,
  input  logic [31:0]    cpl_data_i
);
  logic launch, busy, isr, expire, np, is_rd;
  logic [DW-1:0] stat, rdata;
  logic [3:0] strb_q;

  cfg_pio_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .busy_i(busy), .isr_i(isr), .stat_i(stat), .rdata_i(rdata),
    .type_o(req_type_o), .bypass_o(req_win_bypass_o), .cfg_addr_o(req_addr_o),
    .wdata_o(req_wdata_o), .strb_o(strb_q), .bus_rdata_o(bus_rdata_o)
  );

  cfg_pio_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i, .rst_ni, .clr_i(launch), .run_i(busy), .expire_o(expire)
  );

  assign np    = (req_type_o[3:2] == 2'b10);
  assign is_rd = (req_type_o == 4'h8) || (req_type_o == 4'h9);
  assign req_strb_o = is_rd ? 4'hF : strb_q;

  cfg_pio_seq u_seq (
    .clk_i, .rst_ni,
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wbit0_i(bus_wdata_i[0]),
    .np_i(np), .expire_i(expire),
    .req_ready_i, .cpl_valid_i, .cpl_status_i, .cpl_data_i,
    .launch_o(launch), .busy_o(busy), .req_valid_o,
    .isr_o(isr), .stat_o(stat), .rdata_o(rdata)
  );

  AST_LAUNCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |-> (!busy && !isr)); // R3
endmodule

// File: tb/cfg_pio_engine_tb_top.sv
module cfg_pio_engine_tb_top;
  localparam int TO = 64;
  localparam logic [2:0] A_CTRL = 0, A_STAT = 1, A_ADDR = 2, A_WDATA = 3,
                         A_STRB = 4, A_RDATA = 5, A_START = 6, A_ISR = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic req_valid, req_ready = 1'b0, req_byp;
  logic [3:0] req_type, req_strb;
  logic [31:0] req_addr, req_wdata;
  logic cpl_valid = 1'b0;
  logic [2:0] cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int n_chk = 0, n_bad = 0;
  int ready_dly = 0, cpl_dly = 0;
  bit cpl_en = 1'b1;
  logic [2:0] rsp_code = '0;
  logic [31:0] rsp_data = '0;

  typedef struct packed {
    logic [3:0] t; logic [31:0] a; logic [31:0] d; logic [3:0] s;
  } req_t;
  req_t exp_q[$];

  always #5 clk = ~clk;

  cfg_pio_engine #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_type_o(req_type),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .req_strb_o(req_strb),
    .req_win_bypass_o(req_byp),
    .cpl_valid_i(cpl_valid), .cpl_status_i(cpl_status), .cpl_data_i(cpl_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4 * TO; i++) begin
      @(negedge clk);
      rd(A_START, v);
      if (v == 0) break;
    end
  endtask

  // driver: program, push expectation, launch
  task automatic issue(input logic [3:0] t, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] s);
    req_t e;
    wr(A_CTRL, {7'b0, 1'b0, 20'b0, t});
    wr(A_ADDR, a);
    wr(A_WDATA, d);
    wr(A_STRB, {28'b0, s});
    e.t = t; e.a = a; e.d = d;
    e.s = (t == 4'h8 || t == 4'h9) ? 4'hF : s;
    exp_q.push_back(e);
    wr(A_START, 32'h1);
  endtask

  // monitor / link responder
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        req_t got, e;
        got.t = req_type; got.a = req_addr; got.d = req_wdata; got.s = req_strb;
        for (int i = 0; i < ready_dly; i++) begin
          @(negedge clk);
          check("R4 valid held", {31'b0, req_valid}, 32'h1);
          check("R4 addr stable", req_addr, got.a);
        end
        if (exp_q.size() == 0) begin
          check("R6 unexpected request", 32'h1, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check("R2 req type", {28'b0, got.t}, {28'b0, e.t});
          check("R2 req addr", got.a, e.a);
          check("R9 req strobe", {28'b0, got.s}, {28'b0, e.s});
          if (!(e.t == 4'h8 || e.t == 4'h9)) check("R9 req wdata", got.d, e.d);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check("R4 valid drops", {31'b0, req_valid}, 32'h0);
        if (cpl_en) begin
          for (int i = 0; i < cpl_dly; i++) @(negedge clk);
          cpl_valid = 1'b1; cpl_status = rsp_code; cpl_data = rsp_data;
          @(negedge clk);
          cpl_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R3: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a1;
    a1 = (32'd3 << 20) | (32'd5 << 15) | (32'd2 << 12) | 32'h44;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_chk(A_START, 0, "R1 start");
    rd_chk(A_ISR, 0, "R1 done");
    rd_chk(A_STAT, 0, "R1 status");
    rd_chk(A_RDATA, 0, "R1 rdata");
    rd_chk(A_CTRL, 0, "R1 ctrl");
    rd_chk(A_ADDR, 0, "R1 addr");
    check("R1 req_valid", {31'b0, req_valid}, 0);
    // R2
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk(A_CTRL, 32'h0100_000F, "R2 ctrl mask");
    check("R2 bypass pin", {31'b0, req_byp}, 1);
    wr(A_ADDR, 32'hFFFF_FFFF);
    rd_chk(A_ADDR, 32'h0FFF_FFFC, "R2 addr mask");
    check("R2 addr pin", req_addr, 32'h0FFF_FFFC);
    wr(A_STRB, 32'hFF);
    rd_chk(A_STRB, 32'hF, "R2 strb mask");

    // OK read, programmed strobe overridden
    ready_dly = 2; cpl_dly = 3; cpl_en = 1; rsp_code = 0; rsp_data = 32'hCAFE_1234;
    issue(4'h8, a1, 32'h0, 4'h3);
    rd_chk(A_START, 1, "R3 start busy");
    check("R3 req_valid", {31'b0, req_valid}, 1);
    wait_done();
    rd_chk(A_ISR, 1, "R5 done set");
    rd_chk(A_STAT, 32'h1, "R7 ok nonposted");
    rd_chk(A_RDATA, 32'hCAFE_1234, "R8 rdata ok");
    // launch with done flag set
    wr(A_START, 1);
    check("R6 no launch with done set", {31'b0, req_valid}, 0);
    rd_chk(A_START, 0, "R6 start stays 0");
    wr(A_ISR, 1);
    rd_chk(A_ISR, 0, "R5 done cleared");

    // write type 1, unsupported request, frozen regs
    ready_dly = 4; cpl_dly = 2; rsp_code = 3'd1; rsp_data = 32'h1111_1111;
    issue(4'hB, 32'h0012_3008, 32'h00AB_0000, 4'h4);
    wr(A_ADDR, 32'h0000_0123);
    wr(A_CTRL, 32'h8);
    wr(A_START, 1);
    rd_chk(A_ADDR, 32'h0012_3008, "R11 addr frozen");
    rd_chk(A_CTRL, 32'hB, "R11 ctrl frozen");
    wait_done();
    rd_chk(A_STAT, 32'h81, "R7 unsupported");
    rd_chk(A_RDATA, 32'hCAFE_1234, "R8 rdata kept on UR");
    wr(A_ISR, 1);

    // retry status
    ready_dly = 0; cpl_dly = 0; rsp_code = 3'd2;
    issue(4'h9, 32'h0100_0010, 32'h0, 4'h0);
    wait_done();
    rd_chk(A_STAT, 32'h101, "R7 retry");
    rd_chk(A_RDATA, 32'hCAFE_1234, "R8 rdata kept on retry");
    wr(A_ISR, 1);

    // completer abort
    rsp_code = 3'd4;
    issue(4'hA, 32'h0000_0004, 32'h0000_BEEF, 4'h3);
    wait_done();
    rd_chk(A_STAT, 32'h201, "R7 abort");
    wr(A_ISR, 1);

    // timeout
    cpl_en = 0;
    issue(4'h8, a1, 32'h0, 4'h0);
    repeat (TO - 8) @(negedge clk);
    rd_chk(A_START, 1, "R10 still busy before limit");
    wait_done();
    rd_chk(A_START, 0, "R10 start cleared");
    rd_chk(A_ISR, 1, "R10 done set");
    rd_chk(A_STAT, 32'h401, "R10 timeout status");
    rd_chk(A_RDATA, 32'hFFFF_FFFF, "R10 rdata ones");
    wr(A_ISR, 1);

    // non-config code: posted flag clear, strobe passes through
    cpl_en = 1; rsp_code = 0; rsp_data = 32'h5A5A_0001;
    issue(4'h4, 32'h0000_0100, 32'h0000_00CC, 4'h1);
    wait_done();
    rd_chk(A_STAT, 32'h0, "R7 non-config posted");
    rd_chk(A_RDATA, 32'h5A5A_0001, "R8 rdata updated");
    wr(A_ISR, 1);

    repeat (5) @(negedge clk);
    check("R6 all requests seen once", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule